// File: doc/BRIEF.md
# Shader call-return program sequencer

This block is the program-counter and subroutine-return controller for a small shader processor. A start pulse loads the program counter with an entry word offset and begins a run. From then on, each valid instruction, already decoded elsewhere into a class (call, return or other) together with its target word offset, moves the fetch address. The fetch address drives instruction memory. A call jumps to its target and saves its own address on a return stack. A return resumes at the word after the saved call.

The return stack holds eight addresses. Every slot, and the empty bottom of the stack, reads as an all-ones marker. A return that finds this marker on top ends the whole run with a one-cycle done pulse, so the program itself has no separate halt instruction. A call issued with all eight slots in use raises an overflow error and stops the run. The datapath and the instruction decoding are outside this block.

Top module: `shader_seq`

## Requirements
- R1: While reset is held, and after it until a start, busy_o, done_o and ovf_o are 0 and fetch_addr_o is 0.
- R2: A start_i sampled while idle makes busy_o 1 and fetch_addr_o equal to entry_i one cycle later. A start_i sampled while a run is active has no effect.
- R3: During a run, a valid instruction of class 0 or 3 (other) advances fetch_addr_o by one, wrapping from 1023 to 0. A cycle without instr_vld_i leaves fetch_addr_o unchanged.
- R4: A valid instruction of class 1 (call) with fewer than 8 saved addresses loads fetch_addr_o with target_i on the next cycle and saves the call's own address. No extra increment is applied.
- R5: A valid instruction of class 2 (return) whose top saved address is not all-ones loads fetch_addr_o with that address plus one, removes it, and marks the freed slot all-ones.
- R6: A return that finds the stack empty, or an all-ones value on top, gives a done_o pulse of exactly one cycle on the next cycle. busy_o falls the cycle after that pulse.
- R7: A call issued with 8 addresses already saved saves nothing and leaves fetch_addr_o unchanged. It sets ovf_o and clears busy_o on the next cycle, with no done_o pulse. ovf_o stays set until the next accepted start.
- R8: Eight nested calls followed by eight returns resume in last-in first-out order, each return landing one word after its matching call.
- R9: A call placed at word 1023 saves the all-ones value, so the return that pops it ends the run as in R6.
- R10: An accepted start empties the return stack and clears ovf_o, so a return issued straight after the start ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted only while idle) |
| entry_i | input | 10 | Entry word offset of the run |
| instr_vld_i | input | 1 | Current instruction has executed and its class is valid |
| instr_cls_i | input | 2 | 1 = call, 2 = return, 0 or 3 = other |
| target_i | input | 10 | Call target word offset |
| fetch_addr_o | output | 10 | Program counter, the instruction-memory word address |
| busy_o | output | 1 | Run active (includes the done cycle) |
| done_o | output | 1 | One-cycle pulse when a return ends the run |
| ovf_o | output | 1 | Return stack overflow, sticky until the next start |

## Verification
The assertions assume that instr_cls_i and target_i are known whenever instr_vld_i is high. They also assume that the controller outside the block only raises instr_vld_i for an instruction fetched from the current fetch_addr_o. They make no assumption about start_i timing, because a start during a run is defined as ignored. The stimulus keeps all inputs driven to known values in every cycle, including idle ones. It deliberately raises start_i and instr_vld_i while idle, in the done cycle and while busy, so the ignore paths are exercised as well.

// File: rtl/shader_seq_pkg.sv
package shader_seq_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_CALL  = 2'd1,
    CLS_RET   = 2'd2
  } instr_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/shader_seq_stack.sv
module shader_seq_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  localparam logic [AW-1:0] SENT = '1;

  logic [AW-1:0] slot_q [DEPTH];
  logic [LW-1:0] lvl_q;
  logic [IW-1:0] top_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= SENT;
    end else if (clear_i) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= SENT;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_i && lvl_q == LW'(i)) slot_q[i] <= push_data_i;
        else if (pop_i && lvl_q == LW'(i + 1)) slot_q[i] <= SENT; // freed slot re-marked
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= '0;
    else if (clear_i) lvl_q <= '0;
    else if (push_i)  lvl_q <= lvl_q + LW'(1);
    else if (pop_i)   lvl_q <= lvl_q - LW'(1);
  end

  assign top_idx = IW'(lvl_q - LW'(1));
  assign top_o   = (lvl_q == '0) ? SENT : slot_q[top_idx];
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign level_o = lvl_q;

  assert_push_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (lvl_q != '0));
  assert_push_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |=> (top_o == $past(push_data_i)));
endmodule

// File: rtl/shader_seq_pc.sv
module shader_seq_pc #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          incr_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;
  logic [AW-1:0] base;

  assign base = load_i ? load_addr_i : pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pc_q <= '0;
    else if (load_i || incr_i) pc_q <= base + (incr_i ? AW'(1) : AW'(0));
  end

  assign pc_o = pc_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !incr_i) |=> $stable(pc_o));
endmodule

// File: rtl/shader_seq.sv
module shader_seq
  import shader_seq_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] entry_i,
  input  logic          instr_vld_i,
  input  logic [1:0]    instr_cls_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] SENT = '1;

  seq_state_e    state_q, state_d;
  logic          ovf_q;
  logic          go, act, is_call, is_ret;
  logic          ret_end, ovf_hit, push, pop;
  logic          pc_load, pc_incr;
  logic [AW-1:0] pc_load_addr, top, pc;
  logic          full;
  logic [LW-1:0] level;

  assign go      = start_i && (state_q == ST_IDLE);
  assign act     = instr_vld_i && (state_q == ST_RUN);
  assign is_call = act && (instr_cls_i == CLS_CALL);
  assign is_ret  = act && (instr_cls_i == CLS_RET);
  assign ret_end = is_ret && (top == SENT);
  assign ovf_hit = is_call && full;
  assign push    = is_call && !full;
  assign pop     = is_ret && !ret_end;

  // start: entry; call: target; return: saved address then +1; other: +1
  assign pc_load      = go || push || pop;
  assign pc_load_addr = go ? entry_i : (push ? target_i : top);
  assign pc_incr      = pop || (act && !is_call && !is_ret);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_RUN;
      ST_RUN: begin
        if (ret_end)      state_d = ST_FIN;
        else if (ovf_hit) state_d = ST_IDLE;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go)           ovf_q <= 1'b0;
      else if (ovf_hit) ovf_q <= 1'b1;
    end
  end

  shader_seq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (go),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (pc),
    .top_o       (top),
    .full_o      (full),
    .level_o     (level)
  );

  shader_seq_pc #(.AW(AW)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (pc_load),
    .load_addr_i (pc_load_addr),
    .incr_i      (pc_incr),
    .pc_o        (pc)
  );

  assign fetch_addr_o = pc;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign ovf_o        = ovf_q;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (busy_o && fetch_addr_o == $past(entry_i) && level == '0));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !is_call && !is_ret) |=> (fetch_addr_o == $past(fetch_addr_o) + AW'(1)));
  assert_call_jump_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> (fetch_addr_o == $past(target_i)));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  assert_ret_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_end |=> done_o);
  assert_ovf_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (!busy_o && !done_o));
endmodule

// File: tb/tb_shader_seq.sv
`timescale 1ns/1ps
module tb_shader_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       start = 1'b0;
  logic [9:0] entry = '0;
  logic       vld = 1'b0;
  logic [1:0] cls = '0;
  logic [9:0] tgt = '0;
  logic [9:0] fetch;
  logic       busy, done, ovf;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_en = 0;
  string cur_req = "R1";

  // reference model state
  int m_state = 0;   // 0 idle, 1 run, 2 finishing
  int m_pc = 0;
  bit m_ovf = 0;
  int q[$];

  always #2 clk = ~clk;

  shader_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .entry_i(entry),
    .instr_vld_i(vld), .instr_cls_i(cls), .target_i(tgt),
    .fetch_addr_o(fetch), .busy_o(busy), .done_o(done), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pc = 0; m_ovf = 0; q.delete();
    end else begin
      case (m_state)
        0: if (start) begin
          m_pc = int'(entry); q.delete(); m_ovf = 0; m_state = 1;
        end
        2: m_state = 0;
        default: if (vld) begin
          if (cls == 2'd1) begin
            if (q.size() == 8) begin m_ovf = 1; m_state = 0; end
            else begin q.push_back(m_pc); m_pc = int'(tgt); end
          end else if (cls == 2'd2) begin
            int top;
            top = (q.size() == 0) ? 1023 : q[$];
            if (top == 1023) m_state = 2;
            else begin void'(q.pop_back()); m_pc = (top + 1) % 1024; end
          end else begin
            m_pc = (m_pc + 1) % 1024;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      logic [12:0] act, exp;
      act = {fetch, busy, done, ovf};
      exp = {10'(m_pc), m_state != 0, m_state == 2, m_ovf};
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s fetch/busy/done/ovf act=%0d/%0b/%0b/%0b exp=%0d/%0b/%0b/%0b",
                 cur_req, act[12:3], act[2], act[1], act[0], exp[12:3], exp[2], exp[1], exp[0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      bad++;
      $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input bit s, input int e, input bit v, input int c, input int t);
    @(negedge clk);
    start = s; entry = 10'(e); vld = v; cls = 2'(c); tgt = 10'(t);
  endtask
  task automatic op(input int c, input int t); drive(0, 0, 1, c, t); endtask
  task automatic nop(); drive(0, 0, 0, 0, 0); endtask
  task automatic go(input int e); drive(1, e, 0, 0, 0); endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    chk_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; // idle outputs, with stray instructions ignored
    op(1, 77); op(2, 0); nop();

    cur_req = "R2";
    go(100); nop();
    drive(1, 300, 1, 0, 0); // start while busy ignored, step counts
    cur_req = "R3";
    op(0, 0); nop(); op(3, 999); nop(); nop(); op(0, 0);

    cur_req = "R4";
    op(1, 200); op(0, 0); op(1, 300); op(0, 0);
    cur_req = "R5";
    op(2, 0); op(0, 0); op(2, 0); nop();
    cur_req = "R6";
    op(2, 0); drive(1, 9, 1, 1, 5); nop(); nop();

    cur_req = "R3";
    go(1022); op(0, 0); op(0, 0); op(0, 0); op(2, 0); nop();

    cur_req = "R7";
    go(0);
    for (int i = 1; i <= 8; i++) op(1, 10 * i);
    op(1, 500); op(0, 0); nop(); op(1, 1); nop();

    cur_req = "R10";
    go(5); op(2, 0); nop(); nop();

    cur_req = "R8";
    go(40);
    for (int i = 1; i <= 8; i++) begin op(0, 0); op(1, 100 * i); end
    for (int i = 0; i < 8; i++) begin op(0, 0); op(2, 0); end
    op(2, 0); nop(); nop();

    cur_req = "R9";
    go(1020); op(0, 0); op(0, 0); op(0, 0); op(1, 50); op(0, 0); op(2, 0);
    nop(); nop(); nop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule